// File: doc/BRIEF.md
# Floating-point register stack controller

This block keeps an eight-slot stack of 80-bit extended-precision registers (sign, 15-bit biased exponent, 64-bit significand with explicit integer bit). Every slot is reached relative to a 3-bit top pointer: stack position ST(i) lives in physical slot (top + i) mod 8, and each slot carries a valid tag. One operation is taken per clock. An operation can push a constant, read a stack position, or store a result that an external arithmetic unit presents on a result port. A store can go to ST(0) or to ST(i), and it can be followed by a pop.

The block decides the destination slot, pops after the store, and detects stack faults. A push onto a slot that is still tagged valid is an overflow. Reading an empty position, or storing while a source position is empty, is an underflow. Both faults raise the invalid-operation flag and the stack-fault flag. The condition bit tells them apart: 1 for overflow, 0 for underflow. A faulting operation changes no register, no tag and not the top pointer. The pi constant comes from a 66-bit internal significand and is rounded to 64 bits on the fly, following the 2-bit rounding control supplied with the push.

Top module: `fpstk_ctrl`

## Requirements
- R1: After reset, top_o is 0, every slot is empty, and done_o, ie_o, sf_o and c1_o are 0.
- R2: Operation code 1 pushes +0.0 (all 80 bits zero). The top pointer drops by one modulo 8, and the new ST(0) slot becomes valid.
- R3: Operation code 2 pushes pi with sign 0 and exponent 16'h4000 (15-bit field). The significand is 64'hC90FDAA22168C235 for rc_i 00 (nearest-even) and 10 (toward plus infinity). It is 64'hC90FDAA22168C234 for rc_i 01 (toward minus infinity) and 11 (toward zero).
- R4: A push (code 1 or 2) when the slot at top-1 is valid is an overflow. It raises ie_o=1, sf_o=1 and c1_o=1.
- R5: Operation code 3 reads ST(idx_i). If that position is empty, the read is an underflow: ie_o=1, sf_o=1, c1_o=0.
- R6: A read returns on rd_data_o the value held in physical slot (top + idx_i) mod 8. The value appears in the same cycle as done_o.
- R7: Operation code 4 writes res_i into ST(0) and leaves the top pointer unchanged.
- R8: Operation code 5 writes res_i into ST(idx_i) and leaves the top pointer unchanged.
- R9: Operation code 6 writes res_i into ST(idx_i), then pops. The written value is afterwards seen at ST(idx_i-1), and the old top slot becomes empty.
- R10: Operation code 7 ignores idx_i. It writes res_i into ST(1) and then pops, so the result becomes the new ST(0).
- R11: Codes 4 to 7 fault with underflow (ie_o=1, sf_o=1, c1_o=0) when ST(0) is empty or the second source is empty. The second source is ST(idx_i), or ST(1) for code 7.
- R12: Every accepted operation pulses done_o exactly one cycle later, and code 0 does nothing. A cycle without op_valid_i gives done_o=0. A faulting operation leaves all registers, tags and the top pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code (0 to 7) |
| idx_i | input | 3 | Stack position i |
| rc_i | input | 2 | Rounding control for the pi push |
| res_i | input | 80 | Result from the arithmetic unit |
| done_o | output | 1 | Operation completed (one cycle after acceptance) |
| ie_o | output | 1 | Invalid-operation fault |
| sf_o | output | 1 | Stack-fault indicator |
| c1_o | output | 1 | Condition bit: 1 overflow, 0 underflow |
| rd_data_o | output | 80 | Data read by operation code 3 |
| top_o | output | 3 | Current top pointer |

## Verification
Each of done_o, ie_o, sf_o, c1_o and rd_data_o is due exactly one clock after the cycle in which its operation is applied. The effect on top_o and on the stored slots shows from that same cycle on, so a read issued next returns the new value two cycles after the original operation. The bench applies each operation at a falling edge and updates a behavioural model of the stack. It then compares every output at the next falling edge, one full cycle after the rising edge that registers the result. Directed sequences fill, overflow and drain the stack and cover all four rounding modes. A long mixed stretch of random operations follows.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_PUSH_Z  = 3'd1,
    OP_PUSH_PI = 3'd2,
    OP_READ    = 3'd3,
    OP_WR_TOP  = 3'd4,
    OP_WR_IDX  = 3'd5,
    OP_WR_POP  = 3'd6,
    OP_WR_POP1 = 3'd7
  } stk_op_e;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_DOWN = 2'd1,
    RND_UP   = 2'd2,
    RND_ZERO = 2'd3
  } rnd_e;

  // pi with a 66-bit significand, integer bit first
  localparam int          PI_REF_W = 66;
  localparam logic [65:0] PI_REF   = {64'hC90FDAA22168C234, 2'b11};
endpackage

// File: rtl/fpstk_pi_round.sv
module fpstk_pi_round
  import fpstk_pkg::*;
#(
  parameter int SIG_W = 64,
  parameter int EXP_W = 15,
  localparam int DATA_W = 1 + EXP_W + SIG_W
) (
  input  logic [1:0]        rc_i,
  output logic [DATA_W-1:0] val_o
);
  localparam int LOW_W = PI_REF_W - SIG_W;
  localparam int BIAS  = (2 ** (EXP_W - 1)) - 1;

  logic [SIG_W-1:0] trunc;
  logic             guard;
  logic             sticky;
  logic             up;
  logic [SIG_W:0]   sum;
  logic [SIG_W-1:0] sig;
  logic [EXP_W-1:0] expo;

  assign trunc  = PI_REF[PI_REF_W-1 -: SIG_W];
  assign guard  = PI_REF[LOW_W-1];
  assign sticky = |PI_REF[LOW_W-2:0];

  always_comb begin
    case (rnd_e'(rc_i))
      RND_NEAR: up = guard & (sticky | trunc[0]);
      RND_UP:   up = guard | sticky;
      default:  up = 1'b0;
    endcase
  end

  assign sum  = {1'b0, trunc} + {{SIG_W{1'b0}}, up};
  assign sig  = sum[SIG_W] ? {1'b1, {(SIG_W-1){1'b0}}} : sum[SIG_W-1:0];
  assign expo = EXP_W'(BIAS + 1) + {{(EXP_W-1){1'b0}}, sum[SIG_W]};
  assign val_o = {1'b0, expo, sig};
endmodule

// File: rtl/fpstk_tagbank.sv
module fpstk_tagbank #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [AW-1:0]    set_idx,
  input  logic             clr_en,
  input  logic [AW-1:0]    clr_idx,
  output logic [DEPTH-1:0] tag_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        tag_o[g] <= 1'b0;
      else if (set_en && set_idx == AW'(g))
        tag_o[g] <= 1'b1;
      else if (clr_en && clr_idx == AW'(g))
        tag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/fpstk_regfile.sv
module fpstk_regfile #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 80,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
  import fpstk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SIG_W = 64,
  parameter int EXP_W = 15,
  localparam int DATA_W = 1 + EXP_W + SIG_W,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid_i,
  input  logic [2:0]        op_i,
  input  logic [AW-1:0]     idx_i,
  input  logic [1:0]        rc_i,
  input  logic [DATA_W-1:0] res_i,
  output logic              done_o,
  output logic              ie_o,
  output logic              sf_o,
  output logic              c1_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [AW-1:0]     top_o
);
  logic [AW-1:0]     top_q, top_nxt;
  logic [DEPTH-1:0]  tags;
  logic [DATA_W-1:0] pi_val;
  logic [AW-1:0]     slot_new, slot_idx, slot_one, slot_src;
  logic              ovf, unf;
  logic              we, re;
  logic [AW-1:0]     waddr;
  logic [DATA_W-1:0] wdata;
  logic              set_en, clr_en;
  stk_op_e           op;

  assign op       = stk_op_e'(op_i);
  assign slot_new = top_q - 1'b1;
  assign slot_idx = top_q + idx_i;
  assign slot_one = top_q + 1'b1;
  assign slot_src = (op == OP_WR_POP1) ? slot_one : slot_idx;

  fpstk_pi_round #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_pi (
    .rc_i (rc_i),
    .val_o(pi_val)
  );

  always_comb begin
    ovf     = 1'b0;
    unf     = 1'b0;
    we      = 1'b0;
    re      = 1'b0;
    waddr   = top_q;
    wdata   = res_i;
    set_en  = 1'b0;
    clr_en  = 1'b0;
    top_nxt = top_q;
    if (op_valid_i) begin
      case (op)
        OP_PUSH_Z, OP_PUSH_PI: begin
          if (tags[slot_new]) begin
            ovf = 1'b1;
          end else begin
            we      = 1'b1;
            waddr   = slot_new;
            wdata   = (op == OP_PUSH_PI) ? pi_val : '0;
            set_en  = 1'b1;
            top_nxt = slot_new;
          end
        end
        OP_READ: begin
          if (!tags[slot_idx]) unf = 1'b1;
          else                 re  = 1'b1;
        end
        OP_WR_TOP, OP_WR_IDX, OP_WR_POP, OP_WR_POP1: begin
          if (!tags[top_q] || !tags[slot_src]) begin
            unf = 1'b1;
          end else begin
            we    = 1'b1;
            waddr = (op == OP_WR_TOP) ? top_q : slot_src;
            if (op == OP_WR_POP || op == OP_WR_POP1) begin
              clr_en  = 1'b1;
              top_nxt = slot_one;
            end
          end
        end
        default: ;
      endcase
    end
  end

  fpstk_tagbank #(.DEPTH(DEPTH)) u_tags (
    .clk    (clk),
    .rst    (rst),
    .set_en (set_en),
    .set_idx(slot_new),
    .clr_en (clr_en),
    .clr_idx(top_q),
    .tag_o  (tags)
  );

  fpstk_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rf (
    .clk  (clk),
    .we   (we),
    .waddr(waddr),
    .wdata(wdata),
    .re   (re),
    .raddr(slot_idx),
    .rdata(rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q  <= '0;
      done_o <= 1'b0;
      ie_o   <= 1'b0;
      sf_o   <= 1'b0;
      c1_o   <= 1'b0;
    end else begin
      top_q  <= top_nxt;
      done_o <= op_valid_i;
      ie_o   <= ovf | unf;
      sf_o   <= ovf | unf;
      c1_o   <= ovf;
    end
  end

  assign top_o = top_q;
endmodule

// File: rtl/fpstk_chk.sv
module fpstk_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid_i,
  input logic [2:0]    op_i,
  input logic          done_o,
  input logic          ie_o,
  input logic          sf_o,
  input logic          c1_o,
  input logic [AW-1:0] top_o
);
  // R12
  done_follows_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid_i |=> done_o);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> (!done_o && !ie_o && !c1_o));
  // R4
  ovf_flags_chk: assert property (@(posedge clk) disable iff (rst)
    c1_o |-> (ie_o && sf_o));
  // R5
  fault_pair_chk: assert property (@(posedge clk) disable iff (rst)
    ie_o |-> sf_o);
  // R12
  fault_top_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && ie_o) |-> (top_o == $past(top_o)));
  // R2
  push_down_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && (op_i == 3'd1 || op_i == 3'd2)) |=>
      (ie_o || (top_o + 1'b1) == $past(top_o)));
  // R9
  pop_up_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && (op_i == 3'd6 || op_i == 3'd7)) |=>
      (ie_o || top_o == AW'($past(top_o) + 1'b1)));
  // R7
  no_move_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && (op_i == 3'd3 || op_i == 3'd4 || op_i == 3'd5)) |=>
      $stable(top_o));
endmodule

bind fpstk_ctrl fpstk_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid_i(op_valid_i),
  .op_i      (op_i),
  .done_o    (done_o),
  .ie_o      (ie_o),
  .sf_o      (sf_o),
  .c1_o      (c1_o),
  .top_o     (top_o)
);

// File: tb/fpstk_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpstk_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [2:0]  idx_i = '0;
  logic [1:0]  rc_i = '0;
  logic [79:0] res_i = '0;
  logic        done_o, ie_o, sf_o, c1_o;
  logic [79:0] rd_data_o;
  logic [2:0]  top_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [79:0] m_mem [8];
  bit          m_tag [8];
  int          m_top = 0;

  always #2.5 clk = ~clk;

  fpstk_ctrl dut_i (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_i(op_i),
    .idx_i(idx_i), .rc_i(rc_i), .res_i(res_i), .done_o(done_o),
    .ie_o(ie_o), .sf_o(sf_o), .c1_o(c1_o), .rd_data_o(rd_data_o),
    .top_o(top_o)
  );

  function automatic logic [79:0] pi_expect(input logic [1:0] rc);
    logic [63:0] s;
    s = (rc == 2'b00 || rc == 2'b10) ? 64'hC90FDAA22168C235 : 64'hC90FDAA22168C234;
    return {1'b0, 15'h4000, s};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // apply one cycle of stimulus at a falling edge, compare at the next one
  task automatic step(input bit v, input logic [2:0] op, input logic [2:0] idx,
                      input logic [1:0] rc, input logic [79:0] res, input string tag);
    bit e_ie, e_c1, rd_ok;
    logic [79:0] e_rd;
    int s_new, s_i, s_b;
    e_ie = 0; e_c1 = 0; rd_ok = 0; e_rd = '0;
    op_valid_i = v; op_i = op; idx_i = idx; rc_i = rc; res_i = res;
    if (v) begin
      s_new = (m_top + 7) % 8;
      s_i   = (m_top + idx) % 8;
      case (op)
        3'd1, 3'd2: begin
          if (m_tag[s_new]) begin e_ie = 1; e_c1 = 1; end
          else begin
            m_mem[s_new] = (op == 3'd2) ? pi_expect(rc) : 80'd0;
            m_tag[s_new] = 1; m_top = s_new;
          end
        end
        3'd3: begin
          if (!m_tag[s_i]) e_ie = 1;
          else begin rd_ok = 1; e_rd = m_mem[s_i]; end
        end
        3'd4, 3'd5, 3'd6, 3'd7: begin
          s_b = (op == 3'd7) ? (m_top + 1) % 8 : s_i;
          if (!m_tag[m_top] || !m_tag[s_b]) e_ie = 1;
          else begin
            m_mem[(op == 3'd4) ? m_top : s_b] = res;
            if (op >= 3'd6) begin m_tag[m_top] = 0; m_top = (m_top + 1) % 8; end
          end
        end
        default: ;
      endcase
    end
    @(negedge clk);
    check(done_o === v,    tag, "done", 80'(done_o), 80'(v));
    check(ie_o === e_ie,   tag, "ie",   80'(ie_o),   80'(e_ie));
    check(sf_o === e_ie,   tag, "sf",   80'(sf_o),   80'(e_ie));
    check(c1_o === e_c1,   tag, "c1",   80'(c1_o),   80'(e_c1));
    check(top_o === 3'(m_top), tag, "top", 80'(top_o), 80'(m_top));
    if (rd_ok) check(rd_data_o === e_rd, tag, "rd_data", rd_data_o, e_rd);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    string tags [8];
    tags = '{"R12", "R2", "R3", "R5", "R7", "R8", "R9", "R10"};
    for (int k = 0; k < 8; k++) m_tag[k] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(0, 0, 0, 0, 0, "R1");
    step(1, 3'd3, 0, 0, 0, "R5");                 // read empty
    step(1, 3'd4, 0, 0, 80'h1234, "R11");         // write with empty sources
    step(1, 3'd0, 0, 0, 0, "R12");                // no-op
    step(1, 3'd1, 0, 0, 0, "R2");
    step(1, 3'd3, 0, 0, 0, "R2");
    for (int r = 0; r < 4; r++) begin
      step(1, 3'd2, 0, 2'(r), 0, "R3");
      step(1, 3'd3, 0, 0, 0, "R3");
    end
    for (int i = 0; i < 6; i++) step(1, 3'd3, 3'(i), 0, 0, "R6");
    step(1, 3'd5, 3'd6, 0, 80'hAB, "R11");        // ST(6) empty
    for (int i = 0; i < 3; i++) step(1, 3'd1, 0, 0, 0, "R2");
    step(1, 3'd2, 0, 2'b00, 0, "R4");             // full
    step(1, 3'd1, 0, 0, 0, "R4");
    step(1, 3'd3, 0, 0, 0, "R12");
    step(1, 3'd4, 3'd7, 0, 80'hAAAA_5555, "R7");
    step(1, 3'd3, 0, 0, 0, "R7");
    step(1, 3'd5, 3'd3, 0, 80'h1111_2222_3333, "R8");
    step(1, 3'd3, 3'd3, 0, 0, "R8");
    step(1, 3'd6, 3'd2, 0, 80'hC0FFEE, "R9");
    step(1, 3'd3, 3'd1, 0, 0, "R9");
    step(1, 3'd7, 3'd5, 0, 80'hD00D, "R10");
    step(1, 3'd3, 0, 0, 0, "R10");
    step(1, 3'd6, 3'd0, 0, 80'h77, "R9");
    step(0, 3'd1, 0, 0, 0, "R12");
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      step(($urandom_range(0, 7) != 0), op, 3'($urandom_range(0, 7)),
           2'($urandom_range(0, 3)), {$urandom, $urandom, 16'($urandom)}, tags[op]);
    end
    report();
  end
endmodule